// File: doc/BRIEF.md
# Configurable Sampled Input Filter

This block cleans up one asynchronous digital input, for example an external trigger pin feeding a timer, and presents a filtered level to the logic behind it. The raw pin first crosses into the clock domain through a flop synchronizer. A sampling strobe then picks the moments when the synchronized level is looked at. A small state machine counts how many strobes in a row saw a level different from the present output, and flips the output once that count reaches a required number N.

A 4-bit control code picks both the strobe source and N from a fixed, non-uniform table. The strobe either fires on every clock, or is made from a one-cycle reference tick input that an internal divider scales down by 1, 2, 4, 8, 16 or 32. When the code changes, the match counter and the divider restart from zero and the output level stays as it is.

The state machine has two states. `ST_HOLD` is the resting state, with the match counter at zero. The transitions are:
- HOLD to HOLD with a flip: on a differing sample when N is 1.
- HOLD to CONFIRM: on the first differing sample when N is above 1.
- CONFIRM to CONFIRM: on each further differing sample, which raises the count.
- CONFIRM to HOLD with a flip: on the N-th differing sample.
- CONFIRM to HOLD as a restart: on a sample that equals the output, which leaves the output unchanged.
- CONFIRM to HOLD on a code change.

Top module: `sampled_input_filter`

## Requirements
- R1: While reset is low, and after it is released, `filt_out` is 0. Until enough samples are taken, it stays 0.
- R2: The raw input passes two synchronizer flops before sampling. With a code that samples on every clock, an input change driven just after clock edge c appears on `filt_out` right after edge c+N+2.
- R3: Code 0 samples once per `ref_tick` pulse with N=1. Without ticks, a changed input never reaches `filt_out`.
- R4: Codes 1, 2 and 3 sample on every clock, with N of 2, 4 and 8.
- R5: The following codes sample once every D reference ticks: 4 and 5 with D=2, 6 and 7 with D=4, 8 and 9 with D=8. Even codes use N=6 and odd codes use N=8.
- R6: Codes 10, 11 and 12 sample once every 16 ticks, with N of 5, 6 and 8. Codes 13, 14 and 15 sample once every 32 ticks, with N of 5, 6 and 8. The D-th tick after a divider restart is the one that samples.
- R7: A run of N-1 differing samples followed by one sample equal to the output leaves `filt_out` unchanged. The next change then needs N fresh samples.
- R8: In the clock where `filt_code` differs from its previous value, no sample is taken, and the match counter and the divider clear. `filt_out` keeps its level.
- R9: `filt_out` changes only on a clock edge where a sample strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference rate pulse |
| raw_in | input | 1 | Asynchronous raw input |
| filt_code | input | 4 | Sample-rate and count selection code |
| filt_out | output | 1 | Filtered level |

## Verification
The hardest case to reach from the ports is a code change that lands in the middle of a partly filled divider or match count. Only the exact tick of the later output flip shows whether both were cleared. The stimulus gets there in two steps. First it drives reference ticks one at a time under a slow code, stopping with the divider part-way through its count. Then it switches to a code with a smaller divisor, and separately interrupts a partly counted run of fast samples with a new code. In both cases the scoreboard predicts the exact cycle of the flip.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int CODE_W  = 4;
    localparam int MAX_N   = 8;
    localparam int CNT_W   = $clog2(MAX_N + 1);
    localparam int DLOG_W  = 3;
    localparam int DIV_W   = 5;

    typedef struct packed {
        logic              fast;
        logic [DLOG_W-1:0] div_log2;
        logic [CNT_W-1:0]  need;
    } sif_cfg_t;

    typedef enum logic [0:0] {
        ST_HOLD    = 1'b0,
        ST_CONFIRM = 1'b1
    } sif_state_e;

    function automatic sif_cfg_t sif_decode(input logic [CODE_W-1:0] code);
        sif_cfg_t c;
        c = '0;
        case (code)
            4'd0:  begin c.fast = 1'b0; c.div_log2 = 3'd0; c.need = CNT_W'(1); end
            4'd1:  begin c.fast = 1'b1; c.div_log2 = 3'd0; c.need = CNT_W'(2); end
            4'd2:  begin c.fast = 1'b1; c.div_log2 = 3'd0; c.need = CNT_W'(4); end
            4'd3:  begin c.fast = 1'b1; c.div_log2 = 3'd0; c.need = CNT_W'(8); end
            4'd4:  begin c.fast = 1'b0; c.div_log2 = 3'd1; c.need = CNT_W'(6); end
            4'd5:  begin c.fast = 1'b0; c.div_log2 = 3'd1; c.need = CNT_W'(8); end
            4'd6:  begin c.fast = 1'b0; c.div_log2 = 3'd2; c.need = CNT_W'(6); end
            4'd7:  begin c.fast = 1'b0; c.div_log2 = 3'd2; c.need = CNT_W'(8); end
            4'd8:  begin c.fast = 1'b0; c.div_log2 = 3'd3; c.need = CNT_W'(6); end
            4'd9:  begin c.fast = 1'b0; c.div_log2 = 3'd3; c.need = CNT_W'(8); end
            4'd10: begin c.fast = 1'b0; c.div_log2 = 3'd4; c.need = CNT_W'(5); end
            4'd11: begin c.fast = 1'b0; c.div_log2 = 3'd4; c.need = CNT_W'(6); end
            4'd12: begin c.fast = 1'b0; c.div_log2 = 3'd4; c.need = CNT_W'(8); end
            4'd13: begin c.fast = 1'b0; c.div_log2 = 3'd5; c.need = CNT_W'(5); end
            4'd14: begin c.fast = 1'b0; c.div_log2 = 3'd5; c.need = CNT_W'(6); end
            default: begin c.fast = 1'b0; c.div_log2 = 3'd5; c.need = CNT_W'(8); end
        endcase
        return c;
    endfunction
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sif_strobe_gen.sv
module sif_strobe_gen #(
    parameter int DIV_W  = 5,
    parameter int DLOG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fast,
    input  logic [DLOG_W-1:0] div_log2,
    input  logic              ref_tick,
    output logic              strobe
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;
    logic             wrap;

    always_comb begin
        span  = (DIV_W+1)'(1) << div_log2;
        limit = DIV_W'(span - (DIV_W+1)'(1));
        wrap  = (div_cnt == limit);
    end

    assign strobe = !clear && (fast || (ref_tick && wrap));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (clear) begin
            div_cnt <= '0;
        end else if (!fast && ref_tick) begin
            div_cnt <= wrap ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sif_match_fsm.sv
module sif_match_fsm
    import sif_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          strobe,
    input  logic          sample,
    input  logic [CW-1:0] need,
    output logic          filt_out,
    output logic [CW-1:0] match_cnt
);
    sif_state_e state, nxt;
    logic hit, miss, last;

    always_comb begin
        hit  = strobe && (sample != filt_out);
        miss = strobe && (sample == filt_out);
        last = (CW'(match_cnt + 1'b1) == need);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (!clear && hit && !last) nxt = ST_CONFIRM;
            end
            ST_CONFIRM: begin
                if (clear || miss || (hit && last)) nxt = ST_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_out  <= 1'b0;
            match_cnt <= '0;
        end else if (clear) begin
            match_cnt <= '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (hit) begin
                        if (last) filt_out  <= ~filt_out;
                        else      match_cnt <= CW'(1);
                    end
                end
                ST_CONFIRM: begin
                    if (miss) begin
                        match_cnt <= '0;
                    end else if (hit) begin
                        if (last) begin
                            filt_out  <= ~filt_out;
                            match_cnt <= '0;
                        end else begin
                            match_cnt <= match_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sampled_input_filter.sv
module sampled_input_filter
    import sif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              raw_in,
    input  logic [CODE_W-1:0] filt_code,
    output logic              filt_out
);
    logic [CODE_W-1:0] code_q;
    logic              code_chg;
    sif_cfg_t          cfg;
    logic              sync_q;
    logic              strobe;
    logic [CNT_W-1:0]  match_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= filt_code;
    end

    assign code_chg = (filt_code != code_q);

    always_comb cfg = sif_decode(filt_code);

    sif_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_q)
    );

    sif_strobe_gen #(.DIV_W(DIV_W), .DLOG_W(DLOG_W)) strobe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (code_chg),
        .fast     (cfg.fast),
        .div_log2 (cfg.div_log2),
        .ref_tick (ref_tick),
        .strobe   (strobe)
    );

    sif_match_fsm #(.CW(CNT_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (code_chg),
        .strobe    (strobe),
        .sample    (sync_q),
        .need      (cfg.need),
        .filt_out  (filt_out),
        .match_cnt (match_cnt)
    );
endmodule

// File: rtl/sif_filter_chk.sv
module sif_filter_chk
    import sif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ref_tick,
    input logic [CODE_W-1:0] filt_code,
    input logic              filt_out,
    input logic              strobe,
    input logic              code_chg,
    input logic [CNT_W-1:0]  match_cnt
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            out_reset_low_chk: assert (filt_out == 1'b0)
                else $error("filt_out not low in reset");
        end
    end

    // R9
    out_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(filt_out));

    // R3
    slow_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && (filt_code == 4'd0 || filt_code > 4'd3)) |-> !strobe);

    // R8
    code_change_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_chg |-> !strobe);

    // R8
    code_change_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_chg |=> (match_cnt == '0));

    // R7
    cnt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !code_chg) |=> $stable(match_cnt));
endmodule

bind sampled_input_filter sif_filter_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .filt_code (filt_code),
    .filt_out  (filt_out),
    .strobe    (strobe),
    .code_chg  (code_chg),
    .match_cnt (match_cnt)
);

// File: tb/sampled_input_filter_tb_top.sv
`timescale 1ns/1ps
module sampled_input_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       raw_in = 1'b0;
    logic [3:0] filt_code = 4'd0;
    logic       filt_out;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    logic  mon_on = 1'b0;
    logic  last_seen = 1'b0;
    logic  lvl = 1'b0;
    logic  done = 1'b0;

    int    exp_cyc_q[$];
    logic  exp_lvl_q[$];
    string exp_tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sampled_input_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .raw_in    (raw_in),
        .filt_code (filt_code),
        .filt_out  (filt_out)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int c, input logic l, input string tag);
        exp_cyc_q.push_back(c);
        exp_lvl_q.push_back(l);
        exp_tag_q.push_back(tag);
    endtask

    // monitor: pops expected flips and compares them with observed ones
    always @(negedge clk) begin
        if (mon_on && filt_out !== last_seen) begin
            if (exp_cyc_q.size() == 0) begin
                check(1'b0, "R7/R9 unexpected output change", cyc, -1);
            end else begin
                int    ec;
                logic  el;
                string et;
                ec = exp_cyc_q.pop_front();
                el = exp_lvl_q.pop_front();
                et = exp_tag_q.pop_front();
                check(cyc == ec, {et, " flip cycle"}, cyc, ec);
                check(filt_out === el, {et, " flip level"}, int'(filt_out), int'(el));
            end
            last_seen = filt_out;
        end
    end

    task automatic drain(input string tag);
        check(exp_cyc_q.size() == 0, {tag, " expected flip seen"}, exp_cyc_q.size(), 0);
        exp_cyc_q.delete();
        exp_lvl_q.delete();
        exp_tag_q.delete();
    endtask

    task automatic cfg_of(input int c, output bit fast, output int d, output int n);
        fast = 1'b0; d = 1; n = 1;
        if (c == 0) begin
            d = 1; n = 1;
        end else if (c <= 3) begin
            fast = 1'b1; n = 1 << c;
        end else if (c <= 9) begin
            d = 1 << ((c - 2) / 2);
            n = (c % 2 == 1) ? 8 : 6;
        end else begin
            int k;
            d = (c <= 12) ? 16 : 32;
            k = (c <= 12) ? c - 10 : c - 13;
            n = (k == 0) ? 5 : (k == 1) ? 6 : 8;
        end
    endtask

    task automatic tick_n(input int k);
        for (int i = 0; i < k; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_code(input int c);
        filt_code = 4'(c);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_code(input int c);
        bit    fast;
        int    d, n, c0;
        string tag;
        cfg_of(c, fast, d, n);
        tag = fast ? "R2/R4" : (c == 0) ? "R3" : (d <= 8) ? "R5" : "R6";
        set_code(c);
        // glitch of N-1 samples must be rejected
        if (n == 1) begin
            raw_in = ~lvl;
            repeat (6) @(negedge clk);
            check(filt_out === lvl, "R3 no tick no change", int'(filt_out), int'(lvl));
            raw_in = lvl;
            repeat (3) @(negedge clk);
        end else if (fast) begin
            raw_in = ~lvl;
            repeat (n - 1) @(negedge clk);
            raw_in = lvl;
            repeat (4) @(negedge clk);
            check(filt_out === lvl, "R7 fast glitch rejected", int'(filt_out), int'(lvl));
        end else begin
            raw_in = ~lvl;
            repeat (3) @(negedge clk);
            tick_n(d * (n - 1));
            raw_in = lvl;
            repeat (3) @(negedge clk);
            tick_n(d);
            check(filt_out === lvl, "R7 slow glitch rejected", int'(filt_out), int'(lvl));
        end
        // stable run of N samples must pass with exact delay
        raw_in = ~lvl;
        c0 = cyc;
        if (fast) begin
            push_exp(c0 + n + 2, ~lvl, tag);
            repeat (n + 4) @(negedge clk);
        end else begin
            push_exp(c0 + 2 + 2 * d * n, ~lvl, tag);
            repeat (3) @(negedge clk);
            tick_n(d * n);
            repeat (2) @(negedge clk);
        end
        drain(tag);
        lvl = ~lvl;
        check(filt_out === lvl, {tag, " level after run"}, int'(filt_out), int'(lvl));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R0 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        int c1, c2;
        raw_in = 1'b1;
        repeat (5) @(negedge clk);
        check(filt_out === 1'b0, "R1 output low in reset", int'(filt_out), 0);
        raw_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(filt_out === 1'b0, "R1 output low after reset", int'(filt_out), 0);
        last_seen = filt_out;
        mon_on = 1'b1;

        for (int c = 0; c < 16; c++) run_code(c);

        // R8: code change in the middle of a fast count
        set_code(3);
        raw_in = ~lvl;
        repeat (5) @(negedge clk);
        c1 = cyc;
        filt_code = 4'd1;
        push_exp(c1 + 3, ~lvl, "R8 count cleared");
        repeat (6) @(negedge clk);
        drain("R8 count cleared");
        lvl = ~lvl;

        // R8: code change keeps level when input already matches
        filt_code = 4'd2;
        repeat (6) @(negedge clk);
        check(filt_out === lvl, "R8 level kept on code change", int'(filt_out), int'(lvl));

        // R8: code change in the middle of a divider count
        set_code(9);
        raw_in = ~lvl;
        repeat (3) @(negedge clk);
        tick_n(5);
        filt_code = 4'd4;
        repeat (2) @(negedge clk);
        c2 = cyc;
        push_exp(c2 + 25 - 2, ~lvl, "R8 divider cleared");
        tick_n(12);
        repeat (2) @(negedge clk);
        drain("R8 divider cleared");
        lvl = ~lvl;
        check(filt_out === lvl, "R8 level after divider clear", int'(filt_out), int'(lvl));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule